// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 24-bit memory address for a load, store or bit-manipulation operation in a small CPU whose register file mixes 16-bit and 32-bit registers. The decoder presents an addressing mode, a base register number, a 4-bit pair selector, a displacement format and the raw instruction word, and pulses `start`. In the same cycle the block drives three register-file read addresses and takes the three read data words back. It then registers the finished address, which appears with `ea_valid` on the next cycle.

Four modes are handled. The first is a single 16-bit register, zero-extended. The second is a register pair, in which registers below the first wide register are joined with their upper neighbour and wide registers are taken whole. The third is an index register plus a register pair, where the pair is numbered non-linearly and one of two fixed index registers is chosen. The fourth is an absolute address taken from the instruction word. In every mode except absolute, a displacement drawn from the instruction word is added after the base has been formed.

Top module: `ea_gen`

## Requirements
- R1: During and after reset, before any `start`, `ea_valid` is 0 and `ea_addr` is 0.
- R2: `ea_valid` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. Back-to-back starts give back-to-back results.
- R3: Mode 0 (short base): base = low 16 bits of register `base_reg`, zero-extended. The upper bits of a wide register have no effect.
- R4: Mode 1 (pair base) with `base_reg` below 12: base = {r[base_reg+1][15:0], r[base_reg][15:0]}.
- R5: Mode 1 with `base_reg` 12 or above: base = the full 32-bit r[base_reg].
- R6: Mode 2 (indexed pair): the index register is r12 when `pair_sel[3]`=0 and r13 when it is 1.
- R7: Mode 2: with k = `pair_sel[2:0]`, the pair's low register is n = 2k for k<6 and n = 2k+3 otherwise. The address is index + {r[n+1][15:0], r[n][15:0]} + displacement.
- R8: Mode 3 (absolute): the address is {iword[35:32], iword[43:40], iword[31:16]}, or iword[51:32] zero-extended when `disp_fmt`=2. The displacement is not added.
- R9: Displacement by `disp_fmt`: 0 = none, 1 = iword[15:0] sign-extended, 2 = iword[51:32] zero-extended, 3 = {iword[45:40], iword[47:46], iword[53:52], iword[35:32]} zero-extended.
- R10: The sum is taken modulo 2^24, so carries out of bit 23 are dropped.
- R11: `ea_addr` keeps its last value in every cycle that does not follow a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Fields are valid; compute an address |
| mode | input | 2 | 0 short base, 1 pair base, 2 indexed pair, 3 absolute |
| base_reg | input | 5 | Base register number (modes 0 and 1) |
| pair_sel | input | 4 | Index choice and pair number (mode 2) |
| disp_fmt | input | 2 | Displacement format, see R9 |
| iword | input | 54 | Raw instruction bits holding displacement or absolute fields |
| rf_a_addr | output | 5 | Read address: base register or pair low register |
| rf_b_addr | output | 5 | Read address: upper neighbour of `rf_a_addr` |
| rf_c_addr | output | 5 | Read address: index register |
| rf_a_data | input | 32 | Read data for `rf_a_addr` |
| rf_b_data | input | 16 | Low half of the register at `rf_b_addr` |
| rf_c_data | input | 32 | Read data for `rf_c_addr` |
| ea_valid | output | 1 | Address valid strobe |
| ea_addr | output | 24 | Effective address |

## Verification
Every address is due exactly one clock after the cycle in which `start` was sampled high, because one output register lies between the register-file reads and `ea_addr`. The bench drives fields just after a falling edge. At the rising edge it queues the expected address, which its own arithmetic model computes from a behavioural register array. It compares at the next falling edge, so `ea_valid`, `ea_addr` and hold-on-idle are all checked in the cycle they are due. Idle cycles that change the fields confirm that nothing moves without a start.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int HW         = 16,
  parameter int RW         = 5,
  parameter int WIDE_FIRST = 12,
  parameter int IDX_LO     = 12,
  parameter int IDX_HI     = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] base_reg,
  input  logic [3:0]    pair_sel,
  input  logic [1:0]    disp_fmt,
  input  logic [53:0]   iword,
  output logic [RW-1:0] rf_a_addr,
  output logic [RW-1:0] rf_b_addr,
  output logic [RW-1:0] rf_c_addr,
  input  logic [DW-1:0] rf_a_data,
  input  logic [HW-1:0] rf_b_data,
  input  logic [DW-1:0] rf_c_data,
  output logic          ea_valid,
  output logic [AW-1:0] ea_addr
);
  localparam logic [1:0] M_SHORT = 2'd0;
  localparam logic [1:0] M_PAIR  = 2'd1;
  localparam logic [1:0] M_IDX   = 2'd2;
  localparam logic [1:0] M_ABS   = 2'd3;

  logic [2:0]    pid;
  logic [RW-1:0] pair_lo;
  logic [DW-1:0] disp, base, abs_val, pair_val, sum;

  assign pid     = pair_sel[2:0];
  assign pair_lo = (pid < 3'd6) ? (RW'(pid) << 1) : ((RW'(pid) << 1) + RW'(3));

  assign rf_a_addr = (mode == M_IDX) ? pair_lo : base_reg;
  assign rf_b_addr = rf_a_addr + RW'(1);
  assign rf_c_addr = pair_sel[3] ? RW'(IDX_HI) : RW'(IDX_LO);

  assign pair_val = {rf_b_data, rf_a_data[HW-1:0]};

  always_comb begin
    case (disp_fmt)
      2'd1:    disp = {{(DW-16){iword[15]}}, iword[15:0]};
      2'd2:    disp = DW'(iword[51:32]);
      2'd3:    disp = DW'({iword[45:40], iword[47:46], iword[53:52], iword[35:32]});
      default: disp = '0;
    endcase
  end

  assign abs_val = (disp_fmt == 2'd2) ? DW'(iword[51:32])
                                      : DW'({iword[35:32], iword[43:40], iword[31:16]});

  always_comb begin
    case (mode)
      M_SHORT: base = DW'(rf_a_data[HW-1:0]);
      M_PAIR:  base = (base_reg < RW'(WIDE_FIRST)) ? pair_val : rf_a_data;
      M_IDX:   base = rf_c_data + pair_val;
      default: base = '0;
    endcase
  end

  assign sum = (mode == M_ABS) ? abs_val : base + disp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
    end else begin
      ea_valid <= start;
      if (start) ea_addr <= sum[AW-1:0];
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 24,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic [3:0]    pair_sel,
  input logic [RW-1:0] rf_a_addr,
  input logic [RW-1:0] rf_b_addr,
  input logic [RW-1:0] rf_c_addr,
  input logic          ea_valid,
  input logic [AW-1:0] ea_addr
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ea_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !ea_valid); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ea_addr)); // R11
  AST_INDEX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !pair_sel[3]) |-> rf_c_addr == RW'(12)); // R6
  AST_INDEX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && pair_sel[3]) |-> rf_c_addr == RW'(13)); // R6
  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && pair_sel[2:0] < 3'd6) |-> (rf_a_addr[0] == 1'b0 && rf_a_addr < RW'(12))); // R7
  AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && pair_sel[2:0] >= 3'd6) |-> rf_a_addr >= RW'(15)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!ea_valid && ea_addr == '0)); // R1
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [4:0] base_reg = '0;
  logic [3:0] pair_sel = '0;
  logic [1:0] disp_fmt = '0;
  logic [53:0] iword = '0;
  logic [4:0] rf_a_addr, rf_b_addr, rf_c_addr;
  logic [31:0] rf_a_data, rf_c_data;
  logic [15:0] rf_b_data;
  logic ea_valid;
  logic [23:0] ea_addr;

  logic [31:0] rf [32];
  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] pend_exp;
  string pend_tag;
  logic [23:0] last_addr = '0;

  always #10 clk = ~clk;

  assign rf_a_data = rf[rf_a_addr];
  assign rf_b_data = rf[rf_b_addr][15:0];
  assign rf_c_data = rf[rf_c_addr];

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_reg(base_reg),
    .pair_sel(pair_sel), .disp_fmt(disp_fmt), .iword(iword),
    .rf_a_addr(rf_a_addr), .rf_b_addr(rf_b_addr), .rf_c_addr(rf_c_addr),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .rf_c_data(rf_c_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  function automatic logic [23:0] ref_ea(int m, int ra, int sel, int fmt, logic [53:0] w);
    longint d, b, lo, hi;
    int k, n;
    case (fmt)
      1: d = longint'($signed(w[15:0]));
      2: d = longint'(w[51:32]);
      3: d = longint'(w[45:40]) * 256 + longint'(w[47:46]) * 64 +
             longint'(w[53:52]) * 16 + longint'(w[35:32]);
      default: d = 0;
    endcase
    case (m)
      0: b = longint'(rf[ra] % 65536);
      1: begin
        if (ra < 12) b = longint'(rf[ra+1] % 65536) * 65536 + longint'(rf[ra] % 65536);
        else b = longint'(rf[ra]);
      end
      2: begin
        k = sel % 8;
        n = (k < 6) ? 2 * k : 2 * k + 3;
        lo = longint'(rf[n] % 65536);
        hi = longint'(rf[n+1] % 65536);
        b = longint'(rf[(sel >= 8) ? 13 : 12]) + hi * 65536 + lo;
      end
      default: begin
        if (fmt == 2) b = longint'(w[51:32]);
        else b = longint'(w[35:32]) * 1048576 + longint'(w[43:40]) * 65536 + longint'(w[31:16]);
        d = 0;
      end
    endcase
    return 24'((b + d) & 64'hFFFFFF);
  endfunction

  always @(posedge clk) begin
    if (rst_n && start) begin
      exp_q.push_back(pend_exp);
      tag_q.push_back(pend_tag);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (exp_q.size() > 0) begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (ea_valid !== 1'b1 || ea_addr !== e) begin
          errors++;
          $display("FAIL %s (R2): valid=%b addr=%h expected valid=1 addr=%h", t, ea_valid, ea_addr, e);
        end
        last_addr = e;
      end else if (ea_valid !== 1'b0 || ea_addr !== last_addr) begin
        errors++;
        $display("FAIL R2/R11 idle: valid=%b addr=%h expected valid=0 addr=%h", ea_valid, ea_addr, last_addr);
      end
    end
  end

  task automatic issue(int m, int ra, int sel, int fmt, logic [53:0] w, string tag);
    mode = 2'(m); base_reg = 5'(ra); pair_sel = 4'(sel); disp_fmt = 2'(fmt); iword = w;
    pend_exp = ref_ea(m, ra, sel, fmt, w);
    pend_tag = tag;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      mode = 2'(i); base_reg = 5'(i + 3); iword = {27'h5A5A5A5, 27'(i * 977)};
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h1357_0000 + 32'(i) * 32'h0101_1111;
    rf[0]  = 32'h0000_0002; rf[1]  = 32'hABCD_1234;
    rf[12] = 32'h00F0_0000; rf[13] = 32'h0000_0001;
    rf[14] = 32'hFFFF_FFF0;
    rf[15] = 32'h0012_8000; rf[16] = 32'h7777_0003;
    rf[17] = 32'h0000_4444; rf[18] = 32'h0000_0005;
    repeat (3) @(negedge clk);
    checks++;
    if (ea_valid !== 1'b0 || ea_addr !== 24'h0) begin
      errors++;
      $display("FAIL R1: valid=%b addr=%h expected valid=0 addr=000000", ea_valid, ea_addr);
    end
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 1, 0, 1, 54'h0000_0000_FFF1, "R3 short base, negative disp (R9 fmt 1)");
    idle(2);
    issue(0, 14, 0, 0, 54'h0, "R3 wide register upper bits ignored");
    issue(0, 0, 0, 2, 54'h3_F00F_1234_5678, "R9 fmt 2 twenty-bit disp");
    issue(0, 0, 0, 3, 54'h2A_BC35_0000_0000, "R9 fmt 3 fourteen-bit disp");
    issue(1, 0, 0, 1, 54'h0000_0000_0005, "R4 pair r1:r0");
    issue(1, 10, 0, 0, 54'h0, "R4 pair r11:r10");
    issue(1, 13, 0, 2, 54'h0_FFF4_0000_0001, "R5 wide base r13");
    issue(1, 14, 0, 2, 54'h0_0020_0000_0000, "R10 wrap past 24 bits");
    issue(1, 14, 0, 1, 54'h0000_0000_8000, "R10 negative disp on wide base");
    idle(3);
    issue(2, 0, 0, 3, 54'h0F_F100_0000_0001, "R6 index r12 pair 0");
    issue(2, 0, 9, 2, 54'h0_0FF1_0000_0000, "R6 index r13 pair 1");
    issue(2, 0, 5, 0, 54'h0, "R7 pair 5 uses r11:r10");
    issue(2, 0, 6, 1, 54'h0000_0000_0010, "R7 pair 6 uses r16:r15");
    issue(2, 0, 15, 0, 54'h0, "R7 pair 7 uses r18:r17 with r13");
    issue(3, 0, 0, 0, 54'h0_0500_FFF8_0000, "R8 absolute 24-bit assembly");
    issue(3, 0, 0, 1, 54'h0_A1B2_C3D4_7FFF, "R8 absolute ignores disp");
    issue(3, 0, 0, 2, 54'h3_FFFF_7777_1111, "R8 absolute 20-bit");
    idle(4);
    issue(0, 2, 0, 1, 54'h1, "R2 back-to-back first");
    issue(1, 4, 0, 1, 54'h2, "R2 back-to-back second");
    idle(3);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule